// File: doc/BRIEF.md
# Latched One-of-Eight Address Decoder

This block turns a small binary address into a one-hot word. It has eight active-high outputs at the default width. A level-sensitive latch sits in front of the decoder. While its hold control is low the latch is transparent, so the outputs track the live address. While the hold control is high the latch keeps the address it last passed, whatever the live address does.

Two chip selects of opposite polarity gate the outputs directly, after the latch. The decoder drives an output only when the high-true select is 1 and the low-true select is 0. In any other state every output is 0.

Because the selects act after the latch, either select can carry a serial data stream. The addressed output then repeats that stream: in true form through the high-true select and inverted through the low-true one. The selects can also combine a further address bit across two instances to build a wider decoder. An asynchronous reset clears the stored address so that the outputs are never unknown before the first transparent phase.

Top module: `latched_decoder`

## Requirements
- R1: With the selects enabled, address value i drives output bit i to 1 and every other bit to 0. Address bit 0 is the least significant bit.
- R2: While `hold_i` is 0 (and reset is released), the latch is transparent and the outputs follow the live `addr_i`.
- R3: While `hold_i` is 1, the outputs reflect the address present just before `hold_i` rose. Changes on `addr_i` have no effect on the outputs.
- R4: The outputs are enabled only when `sel_hi_i` = 1 and `sel_lo_n_i` = 0.
- R5: For the select pairs (0,0), (0,1) and (1,1) on (`sel_hi_i`, `sel_lo_n_i`), all outputs are 0 whatever the address or the latch state.
- R6: With `sel_lo_n_i` held at 0, the addressed output equals `sel_hi_i`. With `sel_hi_i` held at 1, the addressed output equals the inverse of `sel_lo_n_i`.
- R7: A select change takes effect on the outputs at once while the address is held, and it does not alter the stored address.
- R8: While `arst_ni` is 0, the stored address is 0, so enabled outputs show bit 0 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_ni | input | 1 | Asynchronous reset, active low; clears the stored address |
| addr_i | input | ADDR_W | Live binary address |
| hold_i | input | 1 | 0: latch transparent, 1: latch holds |
| sel_hi_i | input | 1 | Chip select, active high |
| sel_lo_n_i | input | 1 | Chip select, active low |
| y_o | output | 2**ADDR_W | One-hot decoded outputs, active high |

## Verification
The bench builds two instances with the default ADDR_W of 3, so each has eight outputs. At this width it can sweep every address against every select pair and run every live-address value against a held one. A second instance shares the address lines and takes a fourth address bit on its selects in the opposite sense, so the two together decode sixteen ways. This shows that the mixed polarity lets two decoders split an address space without extra gates.

// File: rtl/ltdec_pkg.sv
package ltdec_pkg;

  // Pair of chip selects with opposite polarity.
  typedef struct packed {
    logic hi;    // active high
    logic lo_n;  // active low
  } sel_pair_t;

  // Decoder enable: only the single active combination opens the outputs.
  function automatic logic sel_active(sel_pair_t s);
    return s.hi & ~s.lo_n;
  endfunction

endpackage

// File: rtl/ltdec_addr_latch.sv
module ltdec_addr_latch #(
  parameter int W = 3
) (
  input  logic         arst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  // Level-sensitive storage: transparent while hold_i is low.
  always_latch begin
    if (!arst_ni) begin
      q_o <= '0;
    end else if (!hold_i) begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/ltdec_onehot.sv
module ltdec_onehot #(
  parameter int W = 3,
  parameter int N = 1 << W
) (
  input  logic [W-1:0] addr_i,
  output logic [N-1:0] dec_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign dec_o[i] = (addr_i == W'(i));
  end

endmodule

// File: rtl/ltdec_gate.sv
module ltdec_gate #(
  parameter int N = 8
) (
  input  logic         en_i,
  input  logic [N-1:0] dec_i,
  output logic [N-1:0] y_o
);

  for (genvar i = 0; i < N; i++) begin : g_and
    assign y_o[i] = dec_i[i] & en_i;
  end

endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int ADDR_W = 3
) (
  input  logic                   arst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   hold_i,
  input  logic                   sel_hi_i,
  input  logic                   sel_lo_n_i,
  output logic [(1<<ADDR_W)-1:0] y_o
);
  import ltdec_pkg::*;

  localparam int OUT_N = 1 << ADDR_W;

  // Named internal events for the assertions.
  logic [ADDR_W-1:0] held_addr;
  logic [OUT_N-1:0]  raw_dec;
  logic              chip_on;
  sel_pair_t         sel;

  assign sel     = '{hi: sel_hi_i, lo_n: sel_lo_n_i};
  assign chip_on = sel_active(sel);

  ltdec_addr_latch #(.W(ADDR_W)) u_latch (
    .arst_ni (arst_ni),
    .hold_i  (hold_i),
    .d_i     (addr_i),
    .q_o     (held_addr)
  );

  ltdec_onehot #(.W(ADDR_W), .N(OUT_N)) u_dec (
    .addr_i (held_addr),
    .dec_o  (raw_dec)
  );

  ltdec_gate #(.N(OUT_N)) u_gate (
    .en_i  (chip_on),
    .dec_i (raw_dec),
    .y_o   (y_o)
  );

  always_comb begin
    AST_ONE_OR_NONE: assert ($onehot0(y_o)) else $error("outputs not one-hot"); // R1
    AST_SELECT_HIT: assert (!chip_on || y_o[held_addr]) else $error("stored address not selected"); // R1
    AST_SEL_CLOSED: assert (chip_on || y_o == '0) else $error("output active while deselected"); // R5
    AST_TRANSPARENT: assert (!arst_ni || hold_i || held_addr == addr_i) else $error("latch not following"); // R2
    AST_RESET_CLEAR: assert (arst_ni || held_addr == '0) else $error("reset did not clear address"); // R8
  end

endmodule

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb_top;

  localparam int CLK_P  = 10;
  localparam int AW     = 3;
  localparam int NOUT   = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic            arst_n;
  logic [AW-1:0]   addr;
  logic            hold;
  logic            s_hi, s_lo_n;
  logic [NOUT-1:0] y;

  // Second instance, used only for the cascade scenario.
  logic            c_hi, c_lo_n;
  logic [NOUT-1:0] y_c;

  latched_decoder #(.ADDR_W(AW)) dut_i (
    .arst_ni(arst_n), .addr_i(addr), .hold_i(hold),
    .sel_hi_i(s_hi), .sel_lo_n_i(s_lo_n), .y_o(y)
  );

  latched_decoder #(.ADDR_W(AW)) cas_i (
    .arst_ni(arst_n), .addr_i(addr), .hold_i(hold),
    .sel_hi_i(c_hi), .sel_lo_n_i(c_lo_n), .y_o(y_c)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model: its own copy of the stored address.
  int model_addr = 0;

  function automatic logic [NOUT-1:0] expect_y(int a, logic hi, logic lo_n);
    logic [NOUT-1:0] v;
    for (int i = 0; i < NOUT; i++) v[i] = (i == a) && hi && !lo_n;
    return v;
  endfunction

  task automatic chk(string req, logic [NOUT-1:0] got, logic [NOUT-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
    if (!$onehot0(got)) begin
      errors++;
      $display("FAIL R1 not one-hot got %b expected at most one bit", got);
    end
  endtask

  // Drive, update the model, let the logic settle mid-cycle.
  task automatic apply(int a, logic h, logic hi, logic lo_n);
    @(negedge clk);
    addr = AW'(a); hold = h; s_hi = hi; s_lo_n = lo_n;
    if (!arst_n) model_addr = 0;
    else if (!h) model_addr = a;
    #(CLK_P/4);
  endtask

  task automatic t_reset();
    arst_n = 1'b0; model_addr = 0;
    apply(6, 1'b0, 1'b1, 1'b0);
    chk("R8 reset clears address", y, expect_y(0, 1'b1, 1'b0));
    apply(3, 1'b1, 1'b1, 1'b0);
    chk("R8 reset with hold", y, expect_y(0, 1'b1, 1'b0));
    @(negedge clk); arst_n = 1'b1;
  endtask

  task automatic t_transparent();
    for (int a = 0; a < NOUT; a++) begin
      apply(a, 1'b0, 1'b1, 1'b0);
      chk("R1 R2 transparent decode", y, expect_y(model_addr, 1'b1, 1'b0));
      checks++;
      if (y[a] !== 1'b1) begin
        errors++;
        $display("FAIL R1 bit index got %b expected bit %0d", y, a);
      end
    end
  endtask

  task automatic t_hold();
    apply(5, 1'b0, 1'b1, 1'b0);
    apply(5, 1'b1, 1'b1, 1'b0);
    for (int a = 0; a < NOUT; a++) begin
      apply(a, 1'b1, 1'b1, 1'b0);
      chk("R3 hold ignores live address", y, expect_y(5, 1'b1, 1'b0));
    end
    apply(2, 1'b0, 1'b1, 1'b0);
    chk("R2 release follows again", y, expect_y(2, 1'b1, 1'b0));
  endtask

  task automatic t_selects();
    for (int a = 0; a < NOUT; a++) begin
      for (int c = 0; c < 4; c++) begin
        apply(a, 1'b0, c[1], c[0]);
        chk((c == 2) ? "R4 enabled pair" : "R5 disabled pair",
            y, expect_y(model_addr, c[1], c[0]));
      end
    end
  endtask

  task automatic t_demux();
    logic [7:0] stream = 8'b1011_0010;
    apply(6, 1'b0, 1'b1, 1'b0);
    apply(1, 1'b1, 1'b1, 1'b0);
    for (int b = 0; b < 8; b++) begin
      apply(1, 1'b1, stream[b], 1'b0);
      chk("R6 data through high select", y, {1'b0, stream[b], 6'b0});
    end
    for (int b = 0; b < 8; b++) begin
      apply(3, 1'b1, 1'b1, stream[b]);
      chk("R6 inverted data through low select", y, {1'b0, ~stream[b], 6'b0});
    end
  endtask

  task automatic t_sel_while_held();
    apply(4, 1'b0, 1'b1, 1'b0);
    apply(7, 1'b1, 1'b1, 1'b0);
    apply(7, 1'b1, 1'b0, 1'b0);
    chk("R7 deselect while held", y, '0);
    apply(0, 1'b1, 1'b1, 1'b1);
    chk("R7 low select off while held", y, '0);
    apply(1, 1'b1, 1'b1, 1'b0);
    chk("R7 stored address kept", y, expect_y(4, 1'b1, 1'b0));
  endtask

  task automatic t_cascade();
    for (int a = 0; a < 2*NOUT; a++) begin
      @(negedge clk);
      addr = AW'(a); hold = 1'b0;
      s_hi = 1'b1; s_lo_n = a[AW];
      c_hi = a[AW]; c_lo_n = 1'b0;
      model_addr = a % NOUT;
      #(CLK_P/4);
      chk("R4 cascade lower", y, expect_y(model_addr, 1'b1, a[AW]));
      chk("R4 cascade upper", y_c, expect_y(model_addr, a[AW], 1'b0));
    end
    c_hi = 1'b0; c_lo_n = 1'b1;
  endtask

  initial begin
    arst_n = 1'b0; addr = '0; hold = 1'b0;
    s_hi = 1'b0; s_lo_n = 1'b1; c_hi = 1'b0; c_lo_n = 1'b1;
    t_reset();
    t_transparent();
    t_hold();
    t_selects();
    t_demux();
    t_sel_while_held();
    t_cascade();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule